// File: doc/BRIEF.md
# Digit-Serial Trinomial Field Multiplier

This block multiplies two elements of the binary field GF(2^M). The field is defined by the irreducible trinomial x^M + x^K + 1. Results use the polynomial basis: bit i of a word is the coefficient of x^i. The multiplier operand B is consumed D bits per clock, least significant digit first. When M is not a multiple of D, B is zero-extended at the top to a whole number of digits.

The multiplicand A sits in a register that is multiplied by x^D modulo the trinomial after each digit. The fold of the overflow bits back into positions 0 and K needs D <= M-K and D < M. Each digit-times-multiplicand step is cut into D-wide chunks, and each chunk is a small Toeplitz matrix-vector product. When D is even, every chunk is split once into halves. The three half-size point products (low, high, sum of halves) are XORed into an accumulator that stays in this point form. Because reconstruction is linear, it runs only once, after the last digit. A single reduction modulo the trinomial then follows, with a register between the two.

Operands enter through a valid/ready port and the product leaves through a valid/ready port. Back-pressure rules: an operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. Once raised, `out_valid` and `out_c` stay put until an edge with `out_ready` high. Only after that transfer does `in_ready` return.

Top module: `gf_dsm_mul`

## Requirements
- R1: After reset and between operations, `in_ready` is 1. An edge with `in_valid` and `in_ready` both high captures `in_a` and `in_b` as one operation.
- R2: `out_c` equals in_a·in_b mod (x^M + x^K + 1), where bit i of each word is the coefficient of x^i.
- R3: `out_valid` first reads 1 after the (ceil(M/D)+2)-th rising edge that follows the accepting edge.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_c` stays unchanged. After an edge with both high, `out_valid` is 0 and `in_ready` is 1.
- R5: From the accepting edge until the result is transferred, `in_ready` is 0. `in_valid` and operand changes in that window have no effect on the result under way.
- R6: An active-low asynchronous reset gives `out_valid` = 0, `in_ready` = 1 and `out_c` = 0, even when it is applied in the middle of an operation.
- R7: A zero operand gives a zero product. An operand equal to 1 gives the other operand unchanged.
- R8: The product is correct when the top, zero-padded digit of B carries set bits, including the case where both operands are all ones.
- R9: Successive operations are independent. No state from an earlier product or from an aborted operation leaks into a later product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_a | input | M | Multiplicand, polynomial basis |
| in_b | input | M | Multiplier, polynomial basis, consumed D bits per cycle |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_c | output | M | Product modulo the trinomial |

## Verification
The hardest situation to reach from the ports is a result that is both held by back-pressure and exposed to fresh operands. In that state a stray capture or a late accumulator update would corrupt it silently. The bench gets there by keeping `out_ready` low for several cycles after the result appears. During the whole iteration and hold window it keeps `in_valid` high with different operands, then checks both the held value and the final product. A reset dropped in the middle of the digit iterations, followed at once by a fresh operation, shows that aborted accumulator state does not leak. All-ones operands drive the zero-padded top digit of B.

// File: rtl/gf_dsm_pkg.sv
package gf_dsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_RECON,
    ST_REDUCE,
    ST_HOLD
  } gf_dsm_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/gf_dsm_clmul.sv
// Carry-less product of two N-bit polynomials: a Toeplitz matrix built
// from x_i applied to the vector y_i.
module gf_dsm_clmul #(
  parameter int N = 1
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-2:0] z_o
);

  always_comb begin
    z_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        z_o[i+j] = z_o[i+j] ^ (x_i[i] & y_i[j]);
      end
    end
  end

endmodule

// File: rtl/gf_dsm_pe.sv
// Processing element: point products of one digit against every chunk of
// the multiplicand, XORed into the point-domain accumulator, plus the
// multiplicand advance by x^D modulo the trinomial.
module gf_dsm_pe #(
  parameter  int M    = 7,
  parameter  int K    = 1,
  parameter  int D    = 2,
  localparam int NC   = gf_dsm_pkg::cdiv(M, D),
  localparam int AW   = NC * D,
  localparam bit KA   = (D % 2 == 0),
  localparam int H    = D / 2,
  localparam int PW   = KA ? (2 * H - 1) : (2 * D - 1),
  localparam int NPT  = KA ? 3 : 1,
  localparam int SLOT = NPT * PW,
  localparam int ACCW = NC * SLOT
) (
  input  logic [M-1:0]    a_i,
  input  logic [D-1:0]    digit_i,
  input  logic [ACCW-1:0] acc_i,
  output logic [M-1:0]    a_next_o,
  output logic [ACCW-1:0] acc_next_o
);

  // multiplicand times x^D: overflow bits fold back at 0 and K
  logic [M+D-1:0] shifted;
  logic [D-1:0]   wrap;
  assign shifted  = {a_i, {D{1'b0}}};
  assign wrap     = shifted[M+D-1:M];
  assign a_next_o = shifted[M-1:0] ^ M'(wrap) ^ (M'(wrap) << K);

  logic [AW-1:0]   a_pad;
  logic [ACCW-1:0] pts;
  assign a_pad = AW'(a_i);

  for (genvar j = 0; j < NC; j++) begin : g_chunk
    logic [D-1:0] chunk;
    assign chunk = a_pad[j*D +: D];

    if (KA) begin : g_split
      logic [H-1:0] m_lo, m_hi, m_sum;
      logic [H-1:0] v_lo, v_hi, v_sum;
      assign m_lo  = chunk[H-1:0];
      assign m_hi  = chunk[D-1:H];
      assign m_sum = m_lo ^ m_hi;
      assign v_lo  = digit_i[H-1:0];
      assign v_hi  = digit_i[D-1:H];
      assign v_sum = v_lo ^ v_hi;

      gf_dsm_clmul #(.N(H)) u_lo  (.x_i(m_lo),  .y_i(v_lo),  .z_o(pts[j*SLOT +: PW]));
      gf_dsm_clmul #(.N(H)) u_hi  (.x_i(m_hi),  .y_i(v_hi),  .z_o(pts[j*SLOT + PW +: PW]));
      gf_dsm_clmul #(.N(H)) u_sum (.x_i(m_sum), .y_i(v_sum), .z_o(pts[j*SLOT + 2*PW +: PW]));
    end else begin : g_plain
      gf_dsm_clmul #(.N(D)) u_full (.x_i(chunk), .y_i(digit_i), .z_o(pts[j*SLOT +: PW]));
    end
  end

  assign acc_next_o = acc_i ^ pts;

endmodule

// File: rtl/gf_dsm_frr.sv
// Shared final reconstruction (point domain to unreduced polynomial) and
// reduction modulo x^M + x^K + 1. The two halves are separated by a
// register held in the top module.
module gf_dsm_frr #(
  parameter  int M    = 7,
  parameter  int K    = 1,
  parameter  int D    = 2,
  localparam int NC   = gf_dsm_pkg::cdiv(M, D),
  localparam int AW   = NC * D,
  localparam bit KA   = (D % 2 == 0),
  localparam int H    = D / 2,
  localparam int PW   = KA ? (2 * H - 1) : (2 * D - 1),
  localparam int NPT  = KA ? 3 : 1,
  localparam int SLOT = NPT * PW,
  localparam int ACCW = NC * SLOT,
  localparam int CPW  = 2 * D - 1,
  localparam int PRW  = AW + D - 1
) (
  input  logic [ACCW-1:0] acc_i,
  output logic [PRW-1:0]  recon_o,
  input  logic [PRW-1:0]  recon_i,
  output logic [M-1:0]    red_o
);

  logic [CPW-1:0] chunk_prod [NC];

  for (genvar j = 0; j < NC; j++) begin : g_rec
    if (KA) begin : g_split
      logic [PW-1:0] p_lo, p_hi, p_sum, p_mid;
      assign p_lo  = acc_i[j*SLOT +: PW];
      assign p_hi  = acc_i[j*SLOT + PW +: PW];
      assign p_sum = acc_i[j*SLOT + 2*PW +: PW];
      assign p_mid = p_lo ^ p_hi ^ p_sum;
      assign chunk_prod[j] = CPW'(p_lo) ^ (CPW'(p_mid) << H) ^ (CPW'(p_hi) << (2 * H));
    end else begin : g_plain
      assign chunk_prod[j] = acc_i[j*SLOT +: PW];
    end
  end

  always_comb begin
    recon_o = '0;
    for (int j = 0; j < NC; j++) begin
      recon_o = recon_o ^ (PRW'(chunk_prod[j]) << (j * D));
    end
  end

  logic [PRW-1:0] work;
  always_comb begin
    work = recon_i;
    for (int i = PRW - 1; i >= M; i--) begin
      if (work[i]) begin
        work[i]         = 1'b0;
        work[i - M + K] = ~work[i - M + K];
        work[i - M]     = ~work[i - M];
      end
    end
    red_o = work[M-1:0];
  end

endmodule

// File: rtl/gf_dsm_mul.sv
module gf_dsm_mul #(
  parameter int M = 7,
  parameter int K = 1,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_c
);
  import gf_dsm_pkg::*;

  localparam int NC   = cdiv(M, D);
  localparam int AW   = NC * D;
  localparam bit KA   = (D % 2 == 0);
  localparam int H    = D / 2;
  localparam int PW   = KA ? (2 * H - 1) : (2 * D - 1);
  localparam int NPT  = KA ? 3 : 1;
  localparam int SLOT = NPT * PW;
  localparam int ACCW = NC * SLOT;
  localparam int PRW  = AW + D - 1;
  localparam int CW   = $clog2(NC);

  gf_dsm_state_e   state_q;
  logic [CW-1:0]   cnt_q;
  logic [M-1:0]    a_q;
  logic [AW-1:0]   b_q;
  logic [ACCW-1:0] acc_q;
  logic [PRW-1:0]  recon_q;
  logic [M-1:0]    res_q;

  logic [M-1:0]    a_nx;
  logic [ACCW-1:0] acc_nx;
  logic [PRW-1:0]  recon_d;
  logic [M-1:0]    red_d;

  gf_dsm_pe #(.M(M), .K(K), .D(D)) u_pe (
    .a_i       (a_q),
    .digit_i   (b_q[D-1:0]),
    .acc_i     (acc_q),
    .a_next_o  (a_nx),
    .acc_next_o(acc_nx)
  );

  gf_dsm_frr #(.M(M), .K(K), .D(D)) u_frr (
    .acc_i  (acc_q),
    .recon_o(recon_d),
    .recon_i(recon_q),
    .red_o  (red_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      recon_q <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            a_q     <= in_a;
            b_q     <= AW'(in_b);
            acc_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          a_q   <= a_nx;
          b_q   <= b_q >> D;
          acc_q <= acc_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(NC - 1)) state_q <= ST_RECON;
        end
        ST_RECON: begin
          recon_q <= recon_d;
          state_q <= ST_REDUCE;
        end
        ST_REDUCE: begin
          res_q   <= red_d;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign out_c     = res_q;

endmodule

// File: rtl/gf_dsm_mul_chk.sv
module gf_dsm_mul_chk #(
  parameter int M = 7,
  parameter int D = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [M-1:0] out_c
);

  localparam int NC = gf_dsm_pkg::cdiv(M, D);

  // edges since the accepting edge, counted independently of the design
  logic [31:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_q <= '0;
    else if (in_valid && in_ready)      since_q <= 32'd1;
    else if (out_valid && out_ready)    since_q <= '0;
    else if (since_q != 0 && !out_valid) since_q <= since_q + 32'd1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> since_q == 32'(NC + 3));

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != 0) |-> !in_ready);

  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_c)));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  // R5
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

endmodule

bind gf_dsm_mul gf_dsm_mul_chk #(.M(M), .D(D)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_c    (out_c)
);

// File: tb/gf_dsm_mul_tb_top.sv
module gf_dsm_mul_tb_top;

  localparam int M   = 7;
  localparam int K   = 1;
  localparam int D   = 2;
  localparam int NC  = (M + D - 1) / D;
  localparam int LAT = NC + 2;
  localparam logic [M-1:0] LOWF = (M'(1) << K) | M'(1);

  // {a, b, expected product} for x^7 + x + 1
  localparam logic [3*M-1:0] VEC [6] = '{
    {7'h01, 7'h02, 7'h02},   // 1 * x
    {7'h40, 7'h02, 7'h03},   // x^6 * x = x + 1
    {7'h40, 7'h40, 7'h60},   // x^12 = x^6 + x^5
    {7'h03, 7'h03, 7'h05},   // (x+1)^2
    {7'h00, 7'h5A, 7'h00},   // zero operand
    {7'h7F, 7'h01, 7'h7F}    // identity
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [M-1:0] in_a = '0;
  logic [M-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [M-1:0] out_c;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gf_dsm_mul #(.M(M), .K(K), .D(D)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_c(out_c)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    logic         top;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      top = r[M-1];
      r   = r << 1;
      if (top) r = r ^ LOWF;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // One operation: optional noise on the input port while busy, optional
  // back-pressure cycles before the result is taken.
  task automatic do_op(input logic [M-1:0] a, input logic [M-1:0] b,
                       input int hold, input bit noise, output logic [M-1:0] c);
    int lat;
    @(negedge clk);
    chk("R1 in_ready idle", in_ready, 1);
    in_a = a; in_b = b; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      in_a = ~a; in_b = b ^ 7'h15; in_valid = 1'b1;
      chk("R5 in_ready busy", in_ready, 0);
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R3 latency", lat, LAT);
    c = out_c;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R4 valid held", out_valid, 1);
      chk("R4 data held", out_c, c);
      chk("R5 no ready while held", in_ready, 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R4 valid drops", out_valid, 0);
    chk("R4 ready returns", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [M-1:0] c;
    logic [M-1:0] a, b;

    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 out_valid", out_valid, 0);
    chk("R6 in_ready", in_ready, 1);
    chk("R6 out_c", out_c, 0);
    rst_n = 1'b1;

    // R2 table walk
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][3*M-1:2*M];
      b = VEC[v][2*M-1:M];
      do_op(a, b, 0, 1'b0, c);
      chk("R2 table product", c, VEC[v][M-1:0]);
    end

    // R7 zero and identity in both operand positions
    do_op(7'h00, 7'h7F, 0, 1'b0, c);
    chk("R7 zero multiplier side", c, 0);
    do_op(7'h7F, 7'h00, 0, 1'b0, c);
    chk("R7 zero b", c, 0);
    do_op(7'h01, 7'h39, 0, 1'b0, c);
    chk("R7 identity a", c, 7'h39);

    // R8 padded top digit, all ones
    do_op(7'h7F, 7'h7F, 0, 1'b0, c);
    chk("R8 all ones", c, ref_mul(7'h7F, 7'h7F));
    do_op(7'h2B, 7'h40, 0, 1'b0, c);
    chk("R8 top digit only", c, ref_mul(7'h2B, 7'h40));

    // R4 / R5 back-pressure with input noise while busy
    do_op(7'h55, 7'h6C, 4, 1'b1, c);
    chk("R5 result unaffected", c, ref_mul(7'h55, 7'h6C));

    // R6 reset mid-operation, then R9 clean restart
    @(negedge clk);
    in_a = 7'h7F; in_b = 7'h7F; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 mid-op out_valid", out_valid, 0);
    chk("R6 mid-op in_ready", in_ready, 1);
    chk("R6 mid-op out_c", out_c, 0);
    rst_n = 1'b1;
    do_op(7'h12, 7'h34, 0, 1'b0, c);
    chk("R9 after abort", c, ref_mul(7'h12, 7'h34));

    // R2 / R9 random operands, back to back
    for (int n = 0; n < 40; n++) begin
      a = M'($urandom);
      b = M'($urandom);
      do_op(a, b, n % 3, n[0], c);
      chk("R2 R9 random", c, ref_mul(a, b));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule